// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block drives the data bus while the processor runs its interrupt acknowledge cycles. It watches an active-low acknowledge strobe, counts the pulses of one acknowledge sequence and, for each pulse, presents the correct byte on an 8-bit data output together with a drive enable. It also produces a one-cycle strobe at the point where the in-service bit of the resolved level should be set, and another one-cycle strobe when the whole sequence is over, which an auto end-of-interrupt scheme uses to clear that bit.

Two processor formats are supported and are chosen by a mode input. In call format a sequence has three pulses: a fixed call opcode, then the low byte of the service routine address, then its high byte. In pointer format a sequence has two pulses: the first pulse is silent and the second carries an 8-bit vector pointer. The resolved level, the programmed vector base and the routine high byte come from neighbouring logic. The mode and the level are captured on the first pulse, so they stay fixed for the rest of that sequence.

Top module: `intack_vector_seq`

## Requirements
- R1: While and directly after a synchronous reset, dout is 0x00, dout_en, isr_latch and seq_done are 0, and the next acknowledge pulse is treated as the first pulse of a new sequence.
- R2: In call format (call_mode = 1) the first pulse drives 0xCD on dout with dout_en high.
- R3: In call format the second pulse drives vec_base + 4 * level, truncated to 8 bits.
- R4: In call format the third pulse drives addr_hi.
- R5: In pointer format (call_mode = 0) dout_en stays 0 for the whole first pulse.
- R6: In pointer format the second pulse drives {vec_base[7:3], level} with dout_en high.
- R7: isr_latch is high for exactly one cycle, the cycle after the clock edge that first samples ack_n low in the first pulse (call format) or the second pulse (pointer format), and is 0 on every other pulse.
- R8: seq_done is high for exactly one cycle, the cycle after the edge that samples ack_n high at the end of the final pulse (third in call format, second in pointer format); the following pulse starts a new sequence.
- R9: call_mode and level are sampled at the start of the first pulse; changing them later in the sequence alters neither the bytes nor the pulse count of that sequence.
- R10: dout_en rises in the cycle after the edge that samples ack_n low on a driving pulse, stays high while ack_n stays low, and falls in the cycle after the edge that samples ack_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low, synchronous to clk |
| call_mode | input | 1 | 1 selects three-pulse call format, 0 selects two-pulse pointer format |
| level | input | 3 | Resolved interrupt level number |
| vec_base | input | 8 | Programmed vector base / routine low-address base |
| addr_hi | input | 8 | Programmed routine high address byte |
| dout | output | 8 | Byte presented to the data bus |
| dout_en | output | 1 | Data bus drive enable |
| isr_latch | output | 1 | One-cycle strobe: set the in-service bit now |
| seq_done | output | 1 | One-cycle strobe: acknowledge sequence finished |

## Verification
The hardest situation to reach is a sequence whose inputs change under it: the mode and level must be frozen at the first pulse even when neighbouring logic alters them between pulses, and a reset that lands in the middle of a sequence must send the pulse count back to the start. The stimulus reaches these by running a call-format first pulse, then switching to pointer format and another level before the remaining pulses, and by asserting reset after a lone pointer-format pulse and then opening a call-format sequence. Opcode wrap of the low address byte is reached with a high base and level 7.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  // Position of the current pulse within an acknowledge sequence
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } phase_t;

  // Final pulse index for the selected format
  function automatic phase_t last_phase(input logic call_fmt);
    return call_fmt ? PH_THIRD : PH_SECOND;
  endfunction

  // Pulse on which the in-service bit is to be set
  function automatic phase_t latch_phase(input logic call_fmt);
    return call_fmt ? PH_FIRST : PH_SECOND;
  endfunction
endpackage

// File: rtl/ivs_strobe_edge.sv
module ivs_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall,
  output logic rise,
  output logic strobe_d
);
  // Idle level of the strobe is high
  always_ff @(posedge clk) begin
    if (rst) strobe_d <= 1'b1;
    else     strobe_d <= strobe_n;
  end

  assign fall = strobe_d & ~strobe_n;
  assign rise = ~strobe_d & strobe_n;
endmodule

// File: rtl/ivs_pulse_track.sv
module ivs_pulse_track
  import ivs_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          rise,
  input  logic          call_mode,
  input  logic [LW-1:0] level,
  output phase_t        phase,
  output logic          eff_mode,
  output logic [LW-1:0] eff_level,
  output logic          at_last
);
  logic          mode_q;
  logic [LW-1:0] level_q;
  logic          opening;

  // Live inputs are used only at the very start of a sequence
  assign opening   = fall && (phase == PH_FIRST);
  assign eff_mode  = opening ? call_mode : mode_q;
  assign eff_level = opening ? level     : level_q;
  assign at_last   = (phase == last_phase(eff_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FIRST;
      mode_q  <= 1'b0;
      level_q <= '0;
    end else begin
      if (opening) begin
        mode_q  <= call_mode;
        level_q <= level;
      end
      if (rise) begin
        if (at_last) phase <= PH_FIRST;
        else         phase <= phase_t'(phase + 2'd1);
      end
    end
  end

  p_phase_range_r8: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  p_frozen_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_FIRST) && !fall |=> $stable(mode_q));
endmodule

// File: rtl/ivs_byte_sel.sv
module ivs_byte_sel
  import ivs_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          LW     = 3,
  parameter int          STEP   = 4,
  parameter logic [DW-1:0] OPCODE = 8'hCD
) (
  input  phase_t        phase,
  input  logic          call_fmt,
  input  logic [LW-1:0] lvl,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] hi_byte,
  output logic [DW-1:0] byte_out,
  output logic          drives
);
  localparam logic [DW-1:0] STEP_W = DW'(STEP);

  logic [DW-1:0] call_low;
  logic [DW-1:0] pointer;

  assign call_low = base + (DW'(lvl) * STEP_W);
  assign pointer  = {base[DW-1:LW], lvl};

  always_comb begin
    byte_out = '0;
    drives   = 1'b0;
    if (call_fmt) begin
      drives = 1'b1;
      unique case (phase)
        PH_FIRST:  byte_out = OPCODE;
        PH_SECOND: byte_out = call_low;
        default:   byte_out = hi_byte;
      endcase
    end else if (phase == PH_SECOND) begin
      drives   = 1'b1;
      byte_out = pointer;
    end
  end
endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
  import ivs_pkg::*;
#(
  parameter int            DW     = 8,
  parameter int            LW     = 3,
  parameter int            STEP   = 4,
  parameter logic [DW-1:0] OPCODE = 8'hCD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_n,
  input  logic          call_mode,
  input  logic [LW-1:0] level,
  input  logic [DW-1:0] vec_base,
  input  logic [DW-1:0] addr_hi,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          isr_latch,
  output logic          seq_done
);
  logic          fall, rise, ack_d;
  phase_t        phase;
  logic          eff_mode, at_last, drives;
  logic [LW-1:0] eff_level;
  logic [DW-1:0] next_byte;

  ivs_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (ack_n),
    .fall     (fall),
    .rise     (rise),
    .strobe_d (ack_d)
  );

  ivs_pulse_track #(.LW(LW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .rise      (rise),
    .call_mode (call_mode),
    .level     (level),
    .phase     (phase),
    .eff_mode  (eff_mode),
    .eff_level (eff_level),
    .at_last   (at_last)
  );

  ivs_byte_sel #(.DW(DW), .LW(LW), .STEP(STEP), .OPCODE(OPCODE)) u_sel (
    .phase    (phase),
    .call_fmt (eff_mode),
    .lvl      (eff_level),
    .base     (vec_base),
    .hi_byte  (addr_hi),
    .byte_out (next_byte),
    .drives   (drives)
  );

  // Registered bus outputs and strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      dout_en   <= 1'b0;
      isr_latch <= 1'b0;
      seq_done  <= 1'b0;
    end else begin
      isr_latch <= fall && (phase == latch_phase(eff_mode));
      seq_done  <= rise && at_last;
      if (fall) begin
        dout_en <= drives;
        if (drives) dout <= next_byte;
      end else if (rise) begin
        dout_en <= 1'b0;
      end
    end
  end

  p_en_while_low_r10: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !ack_d);

  p_latch_single_r7: assert property (@(posedge clk) disable iff (rst)
    isr_latch |=> !isr_latch);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  p_done_restart_r8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> phase == PH_FIRST);

  p_ptr_silent_first_r5: assert property (@(posedge clk) disable iff (rst)
    dout_en && (phase == PH_FIRST) |-> dout == OPCODE);

  p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(isr_latch && seq_done));
endmodule

// File: tb/intack_vector_seq_tb.sv
module intack_vector_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ack_n = 1'b1;
  logic       call_mode = 1'b0;
  logic [2:0] level = '0;
  logic [7:0] vec_base = '0;
  logic [7:0] addr_hi = '0;
  logic [7:0] dout;
  logic       dout_en, isr_latch, seq_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  intack_vector_seq u_dut (
    .clk(clk), .rst(rst), .ack_n(ack_n), .call_mode(call_mode),
    .level(level), .vec_base(vec_base), .addr_hi(addr_hi),
    .dout(dout), .dout_en(dout_en), .isr_latch(isr_latch), .seq_done(seq_done)
  );

  // {mode, level, base, hi, byte0, byte1, byte2}
  localparam logic [43:0] VEC [7] = '{
    {1'b1, 3'd0, 8'h40, 8'h12, 8'hCD, 8'h40, 8'h12},
    {1'b1, 3'd5, 8'h40, 8'h9A, 8'hCD, 8'h54, 8'h9A},
    {1'b1, 3'd7, 8'hF0, 8'h01, 8'hCD, 8'h0C, 8'h01},
    {1'b0, 3'd3, 8'h08, 8'h00, 8'h00, 8'h0B, 8'h00},
    {1'b0, 3'd6, 8'hFF, 8'h00, 8'h00, 8'hFE, 8'h00},
    {1'b0, 3'd0, 8'h20, 8'h00, 8'h00, 8'h20, 8'h00},
    {1'b1, 3'd2, 8'h80, 8'h00, 8'hCD, 8'h88, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One acknowledge pulse: low for 3 cycles, then released
  task automatic pulse(input bit exp_en, input logic [7:0] exp_byte,
                       input bit exp_latch, input bit exp_done, input string req);
    @(negedge clk) ack_n = 1'b0;
    @(negedge clk);
    check(dout_en == exp_en, (exp_en ? "R10" : "R5"), dout_en, exp_en);
    if (exp_en) check(dout == exp_byte, req, dout, exp_byte);
    check(isr_latch == exp_latch, "R7", isr_latch, exp_latch);
    @(negedge clk);
    check(isr_latch == 1'b0, "R7", isr_latch, 0);
    check(dout_en == exp_en, "R10", dout_en, exp_en);
    @(negedge clk) ack_n = 1'b1;
    @(negedge clk);
    check(dout_en == 1'b0, "R10", dout_en, 0);
    check(seq_done == exp_done, "R8", seq_done, exp_done);
    @(negedge clk);
    check(seq_done == 1'b0, "R8", seq_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(dout == 8'h00 && !dout_en && !isr_latch && !seq_done, "R1",
          {dout, dout_en, isr_latch, seq_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(dout == 8'h00 && !dout_en && !isr_latch && !seq_done, "R1",
          {dout, dout_en, isr_latch, seq_done}, 0);

    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      call_mode = VEC[i][43];
      level     = VEC[i][42:40];
      vec_base  = VEC[i][39:32];
      addr_hi   = VEC[i][31:24];
      if (VEC[i][43]) begin
        pulse(1'b1, VEC[i][23:16], 1'b1, 1'b0, "R2");
        pulse(1'b1, VEC[i][15:8],  1'b0, 1'b0, "R3");
        pulse(1'b1, VEC[i][7:0],   1'b0, 1'b1, "R4");
      end else begin
        pulse(1'b0, 8'h00,         1'b0, 1'b0, "R5");
        pulse(1'b1, VEC[i][15:8],  1'b1, 1'b1, "R6");
      end
    end

    // R9: mode and level change after the first pulse
    @(negedge clk);
    call_mode = 1'b1; level = 3'd2; vec_base = 8'h80; addr_hi = 8'h3C;
    pulse(1'b1, 8'hCD, 1'b1, 1'b0, "R9");
    call_mode = 1'b0; level = 3'd5;
    pulse(1'b1, 8'h88, 1'b0, 1'b0, "R9");
    pulse(1'b1, 8'h3C, 1'b0, 1'b1, "R9");

    // R1: reset in mid-sequence restarts the pulse count
    @(negedge clk);
    call_mode = 1'b0; level = 3'd1; vec_base = 8'h48;
    pulse(1'b0, 8'h00, 1'b0, 1'b0, "R5");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(dout == 8'h00 && !dout_en, "R1", dout, 0);
    call_mode = 1'b1; level = 3'd1; addr_hi = 8'h77;
    pulse(1'b1, 8'hCD, 1'b1, 1'b0, "R1");
    pulse(1'b1, 8'h4C, 1'b0, 1'b0, "R3");
    pulse(1'b1, 8'h77, 1'b0, 1'b1, "R4");

    // R8: back-to-back pointer sequences restart at the first pulse
    call_mode = 1'b0; level = 3'd7; vec_base = 8'hA0;
    pulse(1'b0, 8'h00, 1'b0, 1'b0, "R8");
    pulse(1'b1, 8'hA7, 1'b1, 1'b1, "R6");
    pulse(1'b0, 8'h00, 1'b0, 1'b0, "R8");
    pulse(1'b1, 8'hA7, 1'b1, 1'b1, "R8");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule